// File: doc/BRIEF.md
# Command Data Timeout Monitor

This block guards a card-interface command sequence against a stalled data phase. A free-running clock divider emits one pulse every `DIV` peripheral clock cycles (10,000 by default). While a command sequence is open, a saturating pulse counter advances on each of those pulses. The running count is compared against a software-writable limit. When a pulse brings the count to or past the limit, a timeout is raised. The total time allowed is therefore the clock period × limit × `DIV`.

A sequence opens on a start strobe. It closes, and the counter returns to zero, on an end strobe or on an abort. While the sequence stays open past the limit, the timeout condition fires again on every later divider pulse. A flag that software has cleared is therefore set again unless the command is aborted first. The error flag is sticky and latches only while the interrupt enable is high. The interrupt request is the flag qualified by that enable.

Top module: `cmd_data_timeout`

## Requirements
- R1: The divider runs from reset regardless of command activity. It pulses once every `DIV` clock cycles, and a start strobe never realigns it.
- R2: The pulse counter resets to 0. It advances by one on each divider pulse seen while a sequence is open (opened at an earlier edge). It never decreases except when cleared.
- R3: A start strobe opens the sequence from the next clock edge onward.
- R4: An end strobe or an abort closes the sequence and clears the counter to 0. If either arrives in the same cycle as a start, the close wins. A sequence closed before reaching the limit raises no error.
- R5: A timeout is detected on a divider pulse whose incremented count is greater than or equal to the limit. The flag is set by that detection only if the interrupt enable is 1 in that cycle.
- R6: The limit register resets to all ones. A write takes effect from the following cycle, and the register reads back on `lim_rdata_o`.
- R7: While the sequence stays open past the limit, every later divider pulse repeats the timeout. A flag cleared in between is set again.
- R8: The error flag holds until a clear strobe. When a set and a clear fall in the same cycle, the set wins.
- R9: The counter saturates at its maximum value instead of wrapping, so a limit of all ones still times out and keeps repeating.
- R10: A limit of 0 times out on the first divider pulse counted after the start.
- R11: `irq_o` is high exactly when the error flag is set and the interrupt enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start_i | input | 1 | Command sequence start strobe |
| cmd_end_i | input | 1 | Command sequence end strobe |
| abort_i | input | 1 | Abort request; closes the sequence |
| irq_en_i | input | 1 | Interrupt enable; gates flag setting and the request |
| lim_we_i | input | 1 | Limit register write strobe |
| lim_wdata_i | input | CNT_W (16) | Limit write data |
| lim_rdata_o | output | CNT_W (16) | Limit register read value |
| flag_clr_i | input | 1 | Error flag clear strobe |
| err_flag_o | output | 1 | Sticky timeout error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The sequence is started at several divider phases. This separates a free-running divider from one that restarts with the command. Limits of 3, 0 and all ones are each run to timeout. These show the greater-or-equal compare, the first-pulse case and saturation against wrap-around. Sequences ended or aborted before the limit, with the enable held low, and with the flag cleared while the sequence is still open show the clearing path, the enable gating and the repeated setting. A clear strobe held high across a pulse shows set-over-clear priority.

// File: rtl/tmo_pkg.sv
// Shared constants for the command data timeout monitor.
// Assumes: nothing beyond the parameter defaults given here.
package tmo_pkg;
    localparam int unsigned TMO_DIV_DEFAULT = 10000;
    localparam int unsigned TMO_CNT_W_DEFAULT = 16;
endpackage

// File: rtl/tmo_prescaler.sv
// Free-running divider: asserts tick_o for one cycle every DIV clocks.
// Assumes: DIV >= 2; never restarted by anything except reset.
module tmo_prescaler #(
    parameter int unsigned DIV = tmo_pkg::TMO_DIV_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Advance the phase and wrap at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    assign tick_o = (phase_q == LAST);
endmodule

// File: rtl/tmo_counter.sv
// Sequence tracker and saturating pulse counter with limit compare.
// Assumes: close (end/abort) has priority over start; limit sampled as held.
module tmo_counter #(
    parameter int unsigned CNT_W = tmo_pkg::TMO_CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             close_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             active_o,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             bump;

    // Saturating next value of the count.
    always_comb begin
        cnt_inc = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
        bump    = active_q && tick_i && !close_i;
    end

    // Open on start, close on end or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)       active_q <= 1'b0;
        else if (close_i) active_q <= 1'b0;
        else if (start_i) active_q <= 1'b1;
    end

    // Count pulses while open; clear on close.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (close_i) cnt_q <= '0;
        else if (bump)    cnt_q <= cnt_inc;
    end

    assign hit_o    = bump && (cnt_inc >= limit_i);
    assign active_o = active_q;
    assign count_o  = cnt_q;
endmodule

// File: rtl/tmo_flag.sv
// Sticky error flag: set by a qualified hit, cleared by strobe, set wins.
// Assumes: hit_i is a single-cycle pulse from the compare logic.
module tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic en_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Latch on an enabled hit, drop on clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)             flag_q <= 1'b0;
        else if (hit_i && en_i) flag_q <= 1'b1;
        else if (clr_i)         flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/cmd_data_timeout.sv
// Top: data timeout monitor for a card command sequence.
// Assumes: strobes are single-cycle and synchronous to clk.
module cmd_data_timeout #(
    parameter int unsigned DIV   = tmo_pkg::TMO_DIV_DEFAULT,
    parameter int unsigned CNT_W = tmo_pkg::TMO_CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start_i,
    input  logic             cmd_end_i,
    input  logic             abort_i,
    input  logic             irq_en_i,
    input  logic             lim_we_i,
    input  logic [CNT_W-1:0] lim_wdata_i,
    output logic [CNT_W-1:0] lim_rdata_o,
    input  logic             flag_clr_i,
    output logic             err_flag_o,
    output logic             irq_o
);
    logic             tick;
    logic             close;
    logic             active;
    logic             hit;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit_q;

    assign close = cmd_end_i || abort_i;

    // Limit register, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= '1;
        else if (lim_we_i) limit_q <= lim_wdata_i;
    end

    tmo_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    tmo_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(cmd_start_i),
        .close_i(close), .limit_i(limit_q), .active_o(active),
        .count_o(count), .hit_o(hit)
    );

    tmo_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .en_i(irq_en_i),
        .clr_i(flag_clr_i), .flag_o(err_flag_o)
    );

    assign lim_rdata_o = limit_q;
    assign irq_o       = err_flag_o && irq_en_i;
endmodule

// File: rtl/tmo_checker.sv
// Property checker for cmd_data_timeout, attached by bind.
// Assumes: observes the top's ports plus the internal count and open state.
module tmo_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start_i,
    input logic             cmd_end_i,
    input logic             abort_i,
    input logic             irq_en_i,
    input logic             flag_clr_i,
    input logic             err_flag_o,
    input logic             irq_o,
    input logic             active,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r2_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_end_i || abort_i) |=> count >= $past(count));
    a_r3_open_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_i && !cmd_end_i && !abort_i) |=> active);
    a_r4_close_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end_i || abort_i) |=> (count == '0 && !active));
    a_r5_enable_gates_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag_o) |-> $past(irq_en_i));
    a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag_o && !flag_clr_i) |=> err_flag_o);
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX && !cmd_end_i && !abort_i) |=> count == CMAX);
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> err_flag_o);
endmodule

bind cmd_data_timeout tmo_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_end_i(cmd_end_i),
    .abort_i(abort_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .err_flag_o(err_flag_o), .irq_o(irq_o), .active(active), .count(count)
);

// File: tb/test_cmd_data_timeout.sv
`timescale 1ns/100ps
module test_cmd_data_timeout;
    localparam int DIV   = 4;
    localparam int CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start_i = 0, cmd_end_i = 0, abort_i = 0, irq_en_i = 0;
    logic lim_we_i = 0, flag_clr_i = 0;
    logic [CNT_W-1:0] lim_wdata_i = '0;
    logic [CNT_W-1:0] lim_rdata_o;
    logic err_flag_o, irq_o;

    always #2.5 clk = ~clk;

    cmd_data_timeout #(.DIV(DIV), .CNT_W(CNT_W)) i_cmd_data_timeout (
        .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_end_i(cmd_end_i),
        .abort_i(abort_i), .irq_en_i(irq_en_i), .lim_we_i(lim_we_i),
        .lim_wdata_i(lim_wdata_i), .lim_rdata_o(lim_rdata_o),
        .flag_clr_i(flag_clr_i), .err_flag_o(err_flag_o), .irq_o(irq_o)
    );

    int vectors = 0, misses = 0, cycles = 0;
    string req = "R6";
    bit done = 0;

    // Behavioural reference state.
    int m_pc = 0, m_open = 0, m_cnt = 0, m_lim = CMAX, m_flag = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_open = 0; m_cnt = 0; m_lim = CMAX; m_flag = 0;
        end else begin
            int pulse, shut, nxt, hit;
            pulse = (m_pc == DIV - 1);
            m_pc  = pulse ? 0 : m_pc + 1;
            shut  = cmd_end_i || abort_i;
            nxt   = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
            hit   = m_open && pulse && !shut && (nxt >= m_lim);
            if (shut) m_cnt = 0; else if (m_open && pulse) m_cnt = nxt;
            if (shut) m_open = 0; else if (cmd_start_i) m_open = 1;
            if (hit && irq_en_i) m_flag = 1; else if (flag_clr_i) m_flag = 0;
            if (lim_we_i) m_lim = lim_wdata_i;
        end
    end

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every clock, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check({req, " err_flag"}, err_flag_o, m_flag);
            check({req, " irq (R11)"}, irq_o, m_flag && irq_en_i);
            check({req, " limit readback (R6)"}, lim_rdata_o, m_lim);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) cmd_start_i = 1; @(negedge clk) cmd_start_i = 0;
    endtask
    task automatic pulse_end();
        @(negedge clk) cmd_end_i = 1; @(negedge clk) cmd_end_i = 0;
    endtask
    task automatic pulse_abort();
        @(negedge clk) abort_i = 1; @(negedge clk) abort_i = 0;
    endtask
    task automatic pulse_clr();
        @(negedge clk) flag_clr_i = 1; @(negedge clk) flag_clr_i = 0;
    endtask
    task automatic write_lim(int v);
        @(negedge clk) lim_we_i = 1; lim_wdata_i = CNT_W'(v);
        @(negedge clk) lim_we_i = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            misses++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        // R6: reset values.
        req = "R6";
        check("R6 reset limit", lim_rdata_o, CMAX);
        check("R8 reset flag", err_flag_o, 0);

        // R1, R2, R3, R5: limit 3, started at several divider phases.
        irq_en_i = 1;
        write_lim(3);
        for (int ph = 0; ph < DIV; ph++) begin
            req = "R1";
            idle(ph);
            pulse_start();
            idle(DIV * 5);
            req = "R5";
            check("R5 flag after limit", err_flag_o, 1);
            pulse_abort();
            pulse_clr();
            check("R8 flag cleared", err_flag_o, 0);
        end

        // R4: end before the limit, no error.
        req = "R4";
        write_lim(6);
        pulse_start();
        idle(DIV * 3);
        pulse_end();
        idle(DIV * 8);
        check("R4 no error after early end", err_flag_o, 0);

        // R4: close and start in the same cycle; close wins.
        @(negedge clk) cmd_start_i = 1; abort_i = 1;
        @(negedge clk) cmd_start_i = 0; abort_i = 0;
        idle(DIV * 10);
        check("R4 close beats start", err_flag_o, 0);

        // R7: clear while still open; flag returns.
        req = "R7";
        write_lim(2);
        pulse_start();
        idle(DIV * 3);
        pulse_clr();
        idle(DIV + 1);
        check("R7 flag set again", err_flag_o, 1);
        pulse_abort();
        pulse_clr();
        idle(DIV * 3);
        check("R7 stays clear after abort", err_flag_o, 0);

        // R8: clear held across a pulse; set wins.
        req = "R8";
        pulse_start();
        @(negedge clk) flag_clr_i = 1;
        idle(DIV * 4);
        flag_clr_i = 0;
        idle(DIV + 1);
        pulse_abort();
        pulse_clr();

        // R5: enable low during timeout, no flag; then enable high.
        req = "R5";
        irq_en_i = 0;
        pulse_start();
        idle(DIV * 5);
        check("R5 gated by enable", err_flag_o, 0);
        irq_en_i = 1;
        idle(DIV + 1);
        check("R5 set once enabled", err_flag_o, 1);
        check("R11 irq follows", irq_o, 1);
        @(negedge clk) irq_en_i = 0;
        #1 check("R11 irq masked", irq_o, 0);
        irq_en_i = 1;
        pulse_abort();
        pulse_clr();

        // R10: limit 0 times out on the first counted pulse.
        req = "R10";
        write_lim(0);
        pulse_start();
        idle(DIV + 1);
        check("R10 first pulse", err_flag_o, 1);
        pulse_abort();
        pulse_clr();

        // R9: limit all ones; saturation then repeat.
        req = "R9";
        write_lim(CMAX);
        pulse_start();
        idle(DIV * (CMAX + 2));
        check("R9 saturated timeout", err_flag_o, 1);
        pulse_clr();
        idle(DIV * 3);
        check("R9 repeats after saturation", err_flag_o, 1);
        pulse_abort();
        pulse_clr();
        idle(4);
        finish_run();
    end
endmodule